// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the clock line for an I2C master and tells a separate bit engine when to move the data line. Four cycle counts, each in system clocks, set the timing: the full SCL period, the SCL low time, the START/STOP setup time, and the data setup time. The high time is whatever the period leaves after the low time. The block drives an open-drain pull-down enable for SCL. It reads the line back, so a target that holds SCL low stretches the high phase instead of shortening it. It issues three single-cycle strobes: change SDA, sample SDA, and condition-slot (the point where a START or STOP edge on SDA is allowed).

For 100 kHz or 400 kHz operation, software programs the period as the system clock rate divided by the bus rate. It programs the low time to about 5/9 of the period, the setup count to half the period, and the data setup to one sixteenth of the period. A run begins with a condition phase that holds SCL released, which is the START slot. Data bits follow for as long as `run_i` stays high. Raising `cond_req_i` before a low phase ends makes the next released phase a condition phase, used for a repeated START or a STOP. Dropping `run_i` ends the run after the current released phase, and SCL then stays released. The block assumes `scl_i` has already been synchronized.

Top module: `scl_timing_gen`

## Requirements
- R1: A synchronous active-high reset, applied at any time, leaves `scl_low_o` at 0 and all three strobes at 0 on the cycle after the reset edge.
- R2: While idle with `run_i` at 0, SCL stays released and no strobe fires, whatever `scl_i` and `cond_req_i` do.
- R3: With no stretching, a data bit holds `scl_low_o` at 1 for L cycles and then at 0 for H = P - L cycles. P and L are the effective period and low time.
- R4: Clamping works as follows. The effective period is P = max(period, 3). The effective low time is L = 1 when the low count is 0, and otherwise L = min(low, P - 2). Both phases therefore last at least one cycle, and the high phase lasts at least two.
- R5: In every low phase, `sda_change_o` pulses exactly once, at zero-based low-cycle index L - 1 - D, where D = min(data setup, L - 1). Exactly D low cycles follow the pulse.
- R6: In every data high phase, `sda_sample_o` pulses exactly once, on the second cycle in which SCL reads high, and `cond_ok_o` stays 0.
- R7: After SCL is released, cycles in which `scl_i` reads 0 are not counted. With K such cycles, the released phase lasts K + H cycles and the sample pulse comes at released cycle K + 1.
- R8: A condition phase keeps SCL released for 2*S counted cycles, where S = max(setup, 1). `cond_ok_o` pulses once, at counted released index S, and `sda_sample_o` does not fire. The first released phase after leaving idle is always a condition phase. A later released phase is a condition phase when `cond_req_i` is 1 on the last low cycle before it.
- R9: If `run_i` is 0 at the end of a released phase, the block returns to idle and SCL stays released. SCL is only pulled low after a cycle in which `run_i` was 1.
- R10: The configuration counts are captured when a run starts from idle. Changes to them during a run have no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Keep clocking bits; 0 ends the run after the current released phase |
| cond_req_i | input | 1 | Make the next released phase a START/STOP condition slot |
| scl_i | input | 1 | Synchronized readback of the SCL line |
| cfg_period_i | input | CNT_W | Full SCL period in system clocks |
| cfg_low_i | input | CNT_W | SCL low time in system clocks |
| cfg_setup_i | input | CNT_W | START hold / repeated START / STOP setup time |
| cfg_dsetup_i | input | CNT_W | SDA setup time before SCL rises |
| scl_low_o | output | 1 | Open-drain enable: 1 pulls SCL low |
| sda_change_o | output | 1 | Strobe: the bit engine may change SDA now |
| sda_sample_o | output | 1 | Strobe: the bit engine should sample SDA now |
| cond_ok_o | output | 1 | Strobe: a START or STOP edge on SDA may be made now |

## Verification
The hardest case to reach from the ports is clock stretching that lands exactly at the hand-off from the low phase into the high phase. That is the cycle in which the generator has released SCL but has not yet seen it high. The bench models the pull-up as the complement of `scl_low_o`, gated by a hold signal. The measurement routine raises the hold on the very first released cycle and drops it after a swept number of cycles. The sweep covers every period from 0 to 7 and every low time from 0 to 8, which drives the clamp into both of its corners. Every run ends with a STOP condition slot followed by an idle window. That checks the return to idle and shows that configuration changes made during the run are ignored.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;

endpackage

// File: rtl/scl_timing_clamp.sv
module scl_timing_clamp #(
  parameter int CNT_W = 12
) (
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] low_i,
  input  logic [CNT_W-1:0] setup_i,
  input  logic [CNT_W-1:0] dsetup_i,
  output logic [CNT_W-1:0] low_len_o,
  output logic [CNT_W-1:0] high_len_o,
  output logic [CNT_W-1:0] chg_at_o,
  output logic [CNT_W-1:0] setup_len_o,
  output logic [CNT_W:0]   cond_len_o
);

  localparam logic [CNT_W-1:0] PER_MIN = CNT_W'(3);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO     = CNT_W'(2);

  logic [CNT_W-1:0] per_eff;
  logic [CNT_W-1:0] low_max;
  logic [CNT_W-1:0] low_eff;
  logic [CNT_W-1:0] dsu_max;
  logic [CNT_W-1:0] dsu_eff;
  logic [CNT_W-1:0] set_eff;

  always_comb begin
    per_eff = (period_i < PER_MIN) ? PER_MIN : period_i;
    low_max = per_eff - TWO;
    if (low_i == '0)          low_eff = ONE;
    else if (low_i > low_max) low_eff = low_max;
    else                      low_eff = low_i;
    dsu_max = low_eff - ONE;
    dsu_eff = (dsetup_i > dsu_max) ? dsu_max : dsetup_i;
    set_eff = (setup_i == '0) ? ONE : setup_i;
  end

  assign low_len_o   = low_eff;
  assign high_len_o  = per_eff - low_eff;
  assign chg_at_o    = dsu_max - dsu_eff;
  assign setup_len_o = set_eff;
  assign cond_len_o  = {set_eff, 1'b0};

endmodule

// File: rtl/scl_timing_phase.sv
module scl_timing_phase
  import scl_timing_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             cond_req_i,
  input  logic             scl_i,
  input  logic [CNT_W-1:0] low_len_i,
  input  logic [CNT_W-1:0] high_len_i,
  input  logic [CNT_W-1:0] chg_at_i,
  input  logic [CNT_W-1:0] setup_len_i,
  input  logic [CNT_W:0]   cond_len_i,
  output logic             load_o,
  output logic             scl_low_o,
  output logic             sda_change_o,
  output logic             sda_sample_o,
  output logic             cond_ok_o
);

  localparam int CW1 = CNT_W + 1;
  localparam logic [CW1-1:0] C_ONE = CW1'(1);

  scl_phase_e     st_q;
  logic [CW1-1:0] cnt_q;
  logic           cond_q;
  logic           sample_q;
  logic           cok_q;

  logic [CW1-1:0] hi_len;
  logic           low_last;
  logic           high_last;
  logic           seen_high;

  assign hi_len    = cond_q ? cond_len_i : {1'b0, high_len_i};
  assign low_last  = (cnt_q == ({1'b0, low_len_i} - C_ONE));
  assign high_last = (cnt_q == (hi_len - C_ONE));
  assign seen_high = (st_q == PH_WAIT) && scl_i;
  assign load_o    = (st_q == PH_IDLE) && run_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= PH_IDLE;
      cnt_q    <= '0;
      cond_q   <= 1'b0;
      sample_q <= 1'b0;
      cok_q    <= 1'b0;
    end else begin
      sample_q <= seen_high && !cond_q;
      cok_q    <= cond_q &&
                  ((seen_high && (setup_len_i == CNT_W'(1))) ||
                   ((st_q == PH_HIGH) && (cnt_q == ({1'b0, setup_len_i} - C_ONE))));
      unique case (st_q)
        PH_IDLE: begin
          if (run_i) begin
            st_q   <= PH_WAIT;
            cond_q <= 1'b1;
            cnt_q  <= '0;
          end
        end
        PH_LOW: begin
          if (low_last) begin
            st_q   <= PH_WAIT;
            cond_q <= cond_req_i;
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q + C_ONE;
          end
        end
        PH_WAIT: begin
          if (scl_i) begin
            st_q  <= PH_HIGH;
            cnt_q <= C_ONE;
          end
        end
        PH_HIGH: begin
          if (high_last) begin
            st_q  <= run_i ? PH_LOW : PH_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + C_ONE;
          end
        end
        default: st_q <= PH_IDLE;
      endcase
    end
  end

  assign scl_low_o    = (st_q == PH_LOW);
  assign sda_change_o = (st_q == PH_LOW) && (cnt_q == {1'b0, chg_at_i});
  assign sda_sample_o = sample_q;
  assign cond_ok_o    = cok_q;

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             cond_req_i,
  input  logic             scl_i,
  input  logic [CNT_W-1:0] cfg_period_i,
  input  logic [CNT_W-1:0] cfg_low_i,
  input  logic [CNT_W-1:0] cfg_setup_i,
  input  logic [CNT_W-1:0] cfg_dsetup_i,
  output logic             scl_low_o,
  output logic             sda_change_o,
  output logic             sda_sample_o,
  output logic             cond_ok_o
);

  logic [CNT_W-1:0] low_d, high_d, chg_d, set_d;
  logic [CNT_W:0]   cond_d;
  logic [CNT_W-1:0] low_q, high_q, chg_q, set_q;
  logic [CNT_W:0]   cond_q;
  logic             load;

  scl_timing_clamp #(.CNT_W(CNT_W)) u_clamp (
    .period_i    (cfg_period_i),
    .low_i       (cfg_low_i),
    .setup_i     (cfg_setup_i),
    .dsetup_i    (cfg_dsetup_i),
    .low_len_o   (low_d),
    .high_len_o  (high_d),
    .chg_at_o    (chg_d),
    .setup_len_o (set_d),
    .cond_len_o  (cond_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      low_q  <= CNT_W'(1);
      high_q <= CNT_W'(2);
      chg_q  <= '0;
      set_q  <= CNT_W'(1);
      cond_q <= (CNT_W+1)'(2);
    end else if (load) begin
      low_q  <= low_d;
      high_q <= high_d;
      chg_q  <= chg_d;
      set_q  <= set_d;
      cond_q <= cond_d;
    end
  end

  scl_timing_phase #(.CNT_W(CNT_W)) u_phase (
    .clk          (clk),
    .rst          (rst),
    .run_i        (run_i),
    .cond_req_i   (cond_req_i),
    .scl_i        (scl_i),
    .low_len_i    (low_q),
    .high_len_i   (high_q),
    .chg_at_i     (chg_q),
    .setup_len_i  (set_q),
    .cond_len_i   (cond_q),
    .load_o       (load),
    .scl_low_o    (scl_low_o),
    .sda_change_o (sda_change_o),
    .sda_sample_o (sda_sample_o),
    .cond_ok_o    (cond_ok_o)
  );

endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk (
  input logic clk,
  input logic rst,
  input logic run_i,
  input logic scl_i,
  input logic scl_low_o,
  input logic sda_change_o,
  input logic sda_sample_o,
  input logic cond_ok_o
);

  // R5: the data-change strobe only falls inside a low phase
  assert_change_in_low_R5: assert property (@(posedge clk) disable iff (rst)
    sda_change_o |-> scl_low_o);

  // R6: sampling only happens while SCL is released
  assert_sample_released_R6: assert property (@(posedge clk) disable iff (rst)
    sda_sample_o |-> !scl_low_o);

  // R8: a condition slot only happens while SCL is released
  assert_cond_released_R8: assert property (@(posedge clk) disable iff (rst)
    cond_ok_o |-> !scl_low_o);

  // R6, R8: strobes never overlap
  assert_strobe_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sda_change_o, sda_sample_o, cond_ok_o}));

  // R7: a line held low right after release keeps the generator waiting
  assert_stretch_wait_R7: assert property (@(posedge clk) disable iff (rst)
    ($fell(scl_low_o) && !scl_i) |=> !scl_low_o);

  // R9: SCL is only pulled low after a cycle with run requested
  assert_low_needs_run_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_low_o) |-> $past(run_i));

endmodule

bind scl_timing_gen scl_timing_gen_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .run_i        (run_i),
  .scl_i        (scl_i),
  .scl_low_o    (scl_low_o),
  .sda_change_o (sda_change_o),
  .sda_sample_o (sda_sample_o),
  .cond_ok_o    (cond_ok_o)
);

// File: tb/scl_timing_gen_bench.sv
module scl_timing_gen_bench;

  localparam int CNT_W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_i = 1'b0;
  logic cond_req_i = 1'b0;
  logic hold_low = 1'b0;
  logic scl_i;
  logic [CNT_W-1:0] cfg_period_i = '0;
  logic [CNT_W-1:0] cfg_low_i = '0;
  logic [CNT_W-1:0] cfg_setup_i = '0;
  logic [CNT_W-1:0] cfg_dsetup_i = '0;
  logic scl_low_o, sda_change_o, sda_sample_o, cond_ok_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  assign scl_i = ~scl_low_o & ~hold_low;

  scl_timing_gen #(.CNT_W(CNT_W)) u_scl_timing_gen (
    .clk          (clk),
    .rst          (rst),
    .run_i        (run_i),
    .cond_req_i   (cond_req_i),
    .scl_i        (scl_i),
    .cfg_period_i (cfg_period_i),
    .cfg_low_i    (cfg_low_i),
    .cfg_setup_i  (cfg_setup_i),
    .cfg_dsetup_i (cfg_dsetup_i),
    .scl_low_o    (scl_low_o),
    .sda_change_o (sda_change_o),
    .sda_sample_o (sda_sample_o),
    .cond_ok_o    (cond_ok_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual=%0d expected=finish", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // Measures a run of cycles with scl_low_o == lvl, starting at the current negedge.
  task automatic meas(input logic lvl, input int stretch, input int maxlen,
                      output int len, output int chg, output int nchg,
                      output int smp, output int nsmp,
                      output int cok, output int ncok);
    len = 0; chg = -1; nchg = 0; smp = -1; nsmp = 0; cok = -1; ncok = 0;
    if (stretch > 0) hold_low = 1'b1;
    while (scl_low_o == lvl && len < maxlen) begin
      if (sda_change_o) begin chg = len; nchg++; end
      if (sda_sample_o) begin smp = len; nsmp++; end
      if (cond_ok_o)    begin cok = len; ncok++; end
      len++;
      @(negedge clk);
      if (len == stretch) hold_low = 1'b0;
    end
    hold_low = 1'b0;
  endtask

  task automatic run_cfg(input int p, input int l, input int d, input int s, input int k);
    int pe, le, he, de, se;
    int len, chg, nchg, smp, nsmp, cok, ncok;
    pe = (p < 3) ? 3 : p;
    le = (l == 0) ? 1 : ((l > pe - 2) ? pe - 2 : l);
    he = pe - le;
    de = (d > le - 1) ? le - 1 : d;
    se = (s == 0) ? 1 : s;

    @(negedge clk);
    cfg_period_i = CNT_W'(p);
    cfg_low_i    = CNT_W'(l);
    cfg_setup_i  = CNT_W'(s);
    cfg_dsetup_i = CNT_W'(d);
    cond_req_i   = 1'b0;
    run_i        = 1'b1;
    @(negedge clk);
    // R10: scramble the configuration after capture
    cfg_period_i = CNT_W'(p + 9);
    cfg_low_i    = CNT_W'(l + 3);
    cfg_setup_i  = CNT_W'(s + 4);
    cfg_dsetup_i = CNT_W'(0);

    meas(1'b0, 0, 300, len, chg, nchg, smp, nsmp, cok, ncok);
    check(len == 2*se, "R8", "start slot length", len, 2*se);
    check(cok == se && ncok == 1, "R8", "start cond_ok index", cok, se);
    check(nsmp == 0, "R8", "no sample in start slot", nsmp, 0);

    meas(1'b1, 0, 300, len, chg, nchg, smp, nsmp, cok, ncok);
    check(len == le, "R3 R4 R10", "low length", len, le);
    check(chg == le - 1 - de && nchg == 1, "R5", "change index", chg, le - 1 - de);

    meas(1'b0, k, 300, len, chg, nchg, smp, nsmp, cok, ncok);
    check(len == he + k, "R3 R4 R7", "released length", len, he + k);
    check(smp == k + 1 && nsmp == 1, "R6 R7", "sample index", smp, k + 1);
    check(ncok == 0, "R6", "no cond_ok in data high", ncok, 0);

    run_i = 1'b0;
    cond_req_i = 1'b1;
    meas(1'b1, 0, 300, len, chg, nchg, smp, nsmp, cok, ncok);
    check(len == le, "R3", "second low length", len, le);

    meas(1'b0, 0, 2*se + 6, len, chg, nchg, smp, nsmp, cok, ncok);
    check(len == 2*se + 6, "R9", "released after stop", len, 2*se + 6);
    check(cok == se && ncok == 1, "R8", "stop cond_ok index", cok, se);
    check(nsmp == 0 && nchg == 0, "R8", "no data strobes in stop slot", nsmp + nchg, 0);
    cond_req_i = 1'b0;
  endtask

  task automatic idle_check();
    int bad;
    bad = 0;
    run_i = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      hold_low   = (i % 3) == 1;
      cond_req_i = (i % 2) == 1;
      if (scl_low_o || sda_change_o || sda_sample_o || cond_ok_o) bad++;
    end
    hold_low = 1'b0;
    cond_req_i = 1'b0;
    check(bad == 0, "R2", "idle activity", bad, 0);
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check({scl_low_o, sda_change_o, sda_sample_o, cond_ok_o} == 4'b0, "R1",
          "reset outputs", int'({scl_low_o, sda_change_o, sda_sample_o, cond_ok_o}), 0);
    rst = 1'b0;
    idle_check();

    // R1: reset in the middle of a low phase
    cfg_period_i = CNT_W'(12);
    cfg_low_i    = CNT_W'(8);
    cfg_setup_i  = CNT_W'(1);
    cfg_dsetup_i = CNT_W'(2);
    run_i = 1'b1;
    repeat (4) @(negedge clk);
    check(scl_low_o == 1'b1, "R1", "low before mid-run reset", int'(scl_low_o), 1);
    rst = 1'b1;
    @(negedge clk);
    check({scl_low_o, sda_change_o, sda_sample_o, cond_ok_o} == 4'b0, "R1",
          "mid-run reset outputs", int'({scl_low_o, sda_change_o, sda_sample_o, cond_ok_o}), 0);
    run_i = 1'b0;
    rst = 1'b0;
    idle_check();

    for (int p = 0; p < 8; p++)
      for (int l = 0; l < 9; l++)
        for (int di = 0; di < 4; di++)
          for (int si = 0; si < 3; si++)
            run_cfg(p, l, (di == 3) ? 7 : di, (si == 2) ? 3 : si, (p + l + di) % 3);

    idle_check();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule